// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the device side of a three-line serial programming port: a serial clock, a data line and a strobe, plus one readback output. A host shifts in a 32-bit word, least significant bit first, one bit per rising serial clock, and then pulses the strobe. The low five bits of the committed word are an address code. Codes 1 to 6 load the whole word into one of six configuration registers, which drive the rest of the chip as plain levels. One fixed code arms a readback instead. The selector in the top nibble picks a configuration register or one of two calibration result words, and that word is then shifted out on the readback pin.

The serial lines are asynchronous to the block clock. Each line passes through a two-stage synchronizer, and the block acts on the edges it detects there. The host sets the pace and cannot be stalled, so the port has no valid/ready handshake and no back-pressure. The configuration outputs are level signals. The calibration words are treated as quasi-static and are captured once, when a readback is armed.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the readback pin is low and all six configuration registers read zero.
- R2: A frame of exactly 32 bits is shifted in LSB first on rising serial clock edges. The strobe commits it. If bits [4:0] hold code k (1 to 6), register k takes the whole 32-bit word. The register changes on the third system clock rising edge, counting the first edge that samples the strobe high.
- R3: If the strobe follows fewer or more than 32 serial clocks, the frame is discarded. The bit count restarts at every strobe, so the next well-formed frame is accepted.
- R4: A committed frame whose code is 0, 7, or 9 to 31 changes no register.
- R5: Code 8 (bits [4:0] = 0,0,0,1,0, bit 3 set) arms a readback and writes no register. Bits [31:28] select the word to return: 1 to 6 select a configuration register, 7 selects calibration word 0 (`cal_words_i[31:0]`), 8 selects calibration word 1 (`cal_words_i[63:32]`), and any other value returns zero. The word is captured at the strobe.
- R6: After a readback strobe, the first rising serial clock is idle and the pin stays low. Each of the next 32 rising edges launches one bit, bit 0 first, on the third system edge counting the first edge that samples the serial clock high. Between edges the pin is stable.
- R7: The pin is low whenever no readback is in progress. After bit 31 it returns low on the falling serial clock edge that follows, with the same latency.
- R8: Serial clocks during a readback are not shifted into the input frame. A write frame sent right after a readback is accepted.
- R9: A strobe during a readback that is not itself a valid readback command aborts it. The pin goes low and the port returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_dat_i | input | 1 | Serial data from the host |
| ser_stb_i | input | 1 | Strobe that ends a write frame |
| cal_words_i | input | 64 | Two 32-bit calibration results, word 0 in the low half |
| rb_dat_o | output | 1 | Readback data to the host |
| cfg_regs_o | output | 192 | Six configuration registers, register 1 in bits [31:0] |

## Verification
The bench targets frames of 31 and 33 bits. A design that committed on any strobe would load these into a register, and one that did not restart its count at the strobe would then reject the next good frame. It reads every selector class, including undefined selectors, and checks that the idle clock emits nothing. An off-by-one in the readback sequencer would show up as every returned word shifted by one bit. It toggles the data line high throughout each readback and then writes immediately afterwards, which catches a port that keeps shifting while it is talking. It also cuts a readback short with a strobe and checks that the pin drops instead of holding a stale bit.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int WORD_W       = 32;
  localparam int CODE_W       = 5;
  localparam int SEL_W        = 4;
  localparam int NUM_REGS_DEF = 6;
  localparam int NUM_CAL_DEF  = 2;
  localparam logic [CODE_W-1:0] RB_CODE = 5'b01000;

  typedef enum logic [1:0] {
    RB_IDLE,
    RB_SKIP,
    RB_SHIFT,
    RB_TAIL
  } rb_phase_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '0;
      else        stage <= {stage[1:0], din[g]};
    end
    assign lvl[g]  = stage[1];
    assign rise[g] = stage[1] & ~stage[2];
    assign fall[g] = ~stage[1] & stage[2];
  end
endmodule

// File: rtl/scp_deser.sv
module scp_deser #(
  parameter int WORD_W = scp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic              stb_rise,
  input  logic              hold,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (stb_rise) begin
      cnt <= '0;
    end else if (bit_rise && !hold) begin
      shreg <= {bit_val, shreg[WORD_W-1:1]};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  assign word_o = shreg;
  assign full_o = (cnt == CNT_FULL);
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
  parameter int WORD_W   = scp_pkg::WORD_W,
  parameter int CODE_W   = scp_pkg::CODE_W,
  parameter int NUM_REGS = scp_pkg::NUM_REGS_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_word,
  output logic [NUM_REGS*WORD_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g + 1);
    logic [WORD_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (wr_en && wr_word[CODE_W-1:0] == MY_CODE) r <= wr_word;
    end
    assign regs_o[g*WORD_W +: WORD_W] = r;
  end
endmodule

// File: rtl/scp_readback.sv
module scp_readback #(
  parameter int WORD_W = scp_pkg::WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               stb_rise,
  input  logic               load,
  input  logic [WORD_W-1:0]  load_word,
  output logic               pin_o,
  output logic               busy_o,
  output scp_pkg::rb_phase_e phase_o
);
  import scp_pkg::*;
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  rb_phase_e         phase;
  logic [WORD_W-1:0] sh;
  logic [IDX_W-1:0]  idx;
  logic              pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RB_IDLE;
      sh    <= '0;
      idx   <= '0;
      pin   <= 1'b0;
    end else if (stb_rise) begin
      pin <= 1'b0;
      idx <= '0;
      if (load) begin
        phase <= RB_SKIP;
        sh    <= load_word;
      end else begin
        phase <= RB_IDLE;
      end
    end else begin
      case (phase)
        RB_SKIP:  if (sclk_rise) phase <= RB_SHIFT;
        RB_SHIFT: if (sclk_rise) begin
          pin <= sh[0];
          sh  <= sh >> 1;
          idx <= idx + 1'b1;
          if (idx == IDX_LAST) phase <= RB_TAIL;
        end
        RB_TAIL:  if (sclk_fall) begin
          pin   <= 1'b0;
          phase <= RB_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign pin_o   = pin;
  assign busy_o  = (phase != RB_IDLE);
  assign phase_o = phase;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NUM_REGS = scp_pkg::NUM_REGS_DEF,
  parameter int NUM_CAL  = scp_pkg::NUM_CAL_DEF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ser_clk_i,
  input  logic                                ser_dat_i,
  input  logic                                ser_stb_i,
  input  logic [NUM_CAL*scp_pkg::WORD_W-1:0]  cal_words_i,
  output logic                                rb_dat_o,
  output logic [NUM_REGS*scp_pkg::WORD_W-1:0] cfg_regs_o
);
  import scp_pkg::*;

  logic [2:0] lvl, rise, fall;
  logic [4:0] sync_unused;
  logic       sclk_rise, sclk_fall, stb_rise, dat_lvl;
  logic [WORD_W-1:0] frame_word, rb_word;
  logic       frame_full, frame_ok, rb_load, rb_busy;
  logic [CODE_W-1:0] frame_code;
  logic [SEL_W-1:0]  rb_sel;
  rb_phase_e  rb_phase;

  scp_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_stb_i, ser_dat_i, ser_clk_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign sclk_rise   = rise[0];
  assign sclk_fall   = fall[0];
  assign dat_lvl     = lvl[1];
  assign stb_rise    = rise[2];
  assign sync_unused = {lvl[2], lvl[0], rise[1], fall[2:1]};

  scp_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(sclk_rise), .bit_val(dat_lvl),
    .stb_rise(stb_rise), .hold(rb_busy),
    .word_o(frame_word), .full_o(frame_full)
  );

  assign frame_ok   = stb_rise & frame_full;
  assign frame_code = frame_word[CODE_W-1:0];
  assign rb_sel     = frame_word[WORD_W-1 -: SEL_W];
  assign rb_load    = frame_ok && (frame_code == RB_CODE);

  scp_regbank #(.WORD_W(WORD_W), .CODE_W(CODE_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(frame_ok), .wr_word(frame_word),
    .regs_o(cfg_regs_o)
  );

  always_comb begin
    rb_word = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rb_sel == SEL_W'(k + 1)) rb_word = cfg_regs_o[k*WORD_W +: WORD_W];
    for (int c = 0; c < NUM_CAL; c++)
      if (rb_sel == SEL_W'(NUM_REGS + 1 + c)) rb_word = cal_words_i[c*WORD_W +: WORD_W];
  end

  scp_readback #(.WORD_W(WORD_W)) u_rb (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .stb_rise(stb_rise), .load(rb_load), .load_word(rb_word),
    .pin_o(rb_dat_o), .busy_o(rb_busy), .phase_o(rb_phase)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int CFG_W = scp_pkg::NUM_REGS_DEF * scp_pkg::WORD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk_rise,
  input logic               sclk_fall,
  input logic               stb_rise,
  input logic               frame_full,
  input logic               frame_ok,
  input logic [4:0]         frame_code,
  input logic               rb_load,
  input logic               rb_busy,
  input scp_pkg::rb_phase_e rb_phase,
  input logic               rb_dat,
  input logic [CFG_W-1:0]   cfg
);
  import scp_pkg::*;

  p_cfg_only_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(cfg));

  p_bad_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !frame_full) |=> $stable(cfg));

  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && (frame_code == 5'd0 || frame_code > 5'd6)) |=> $stable(cfg));

  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_phase == RB_SKIP && sclk_rise && !stb_rise) |=> !rb_dat);

  p_pin_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !sclk_fall && !stb_rise) |=> $stable(rb_dat));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_busy |-> !rb_dat);

  p_no_shift_in_rb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_busy && !stb_rise) |=> $stable(frame_full));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !rb_load) |=> (!rb_dat && !rb_busy));
endmodule

bind serial_cfg_port scp_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .stb_rise(stb_rise),
  .frame_full(frame_full), .frame_ok(frame_ok), .frame_code(frame_code),
  .rb_load(rb_load), .rb_busy(rb_busy), .rb_phase(rb_phase),
  .rb_dat(rb_dat_o), .cfg(cfg_regs_o)
);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 6;
  localparam int NC = 2;
  localparam int W  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sstb = 1'b0;
  logic [NC*W-1:0] cal = {32'h0BAD_F00D, 32'h1357_9BDF};
  logic rb;
  logic [NR*W-1:0] cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port dut (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_stb_i(sstb),
    .cal_words_i(cal), .rb_dat_o(rb), .cfg_regs_o(cfg)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mcfg [NR];
  bit mc[3], md[3], ms[3];
  bit bits[$], rbq[$];
  bit m_act, m_skip, m_tail, exp_pin;
  bit m_r, m_f, m_sr;
  logic [31:0] m_w, m_src;
  int m_code, m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NR; k++) mcfg[k] = '0;
      for (int k = 0; k < 3; k++) begin mc[k] = 0; md[k] = 0; ms[k] = 0; end
      bits.delete(); rbq.delete();
      m_act = 0; m_skip = 0; m_tail = 0; exp_pin = 0;
    end else begin
      m_r  = mc[1] && !mc[2];
      m_f  = !mc[1] && mc[2];
      m_sr = ms[1] && !ms[2];
      if (m_sr) begin
        m_act = 0; m_skip = 0; m_tail = 0; exp_pin = 0;
        if (bits.size() == W) begin
          for (int i = 0; i < W; i++) m_w[i] = bits[i];
          m_code = int'(m_w[4:0]);
          if (m_code >= 1 && m_code <= NR) mcfg[m_code-1] = m_w;
          else if (m_code == 8) begin
            m_sel = int'(m_w[31:28]);
            if (m_sel >= 1 && m_sel <= NR) m_src = mcfg[m_sel-1];
            else if (m_sel == NR + 1)      m_src = cal[31:0];
            else if (m_sel == NR + 2)      m_src = cal[63:32];
            else                           m_src = '0;
            rbq.delete();
            for (int i = 0; i < W; i++) rbq.push_back(m_src[i]);
            m_act = 1; m_skip = 1;
          end
        end
        bits.delete();
      end else if (m_r) begin
        if (m_act) begin
          if (m_skip) m_skip = 0;
          else if (!m_tail) begin
            exp_pin = rbq.pop_front();
            if (rbq.size() == 0) m_tail = 1;
          end
        end else bits.push_back(md[1]);
      end else if (m_f) begin
        if (m_act && m_tail) begin exp_pin = 0; m_act = 0; m_tail = 0; end
      end
      mc[2] = mc[1]; mc[1] = mc[0]; mc[0] = sclk;
      md[2] = md[1]; md[1] = md[0]; md[0] = sdat;
      ms[2] = ms[1]; ms[1] = ms[0]; ms[0] = sstb;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, {31'b0, rb}, {31'b0, exp_pin}, "readback pin vs model");
      for (int k = 0; k < NR; k++)
        check("R2", cfg[k*W +: W], mcfg[k], "config register vs model");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic ser_bit(input bit d, output bit seen);
    sdat = d;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    seen = rb;
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    bit dummy;
    for (int i = 0; i < n; i++) ser_bit(w[i % 32], dummy);
  endtask

  task automatic strobe();
    repeat (2) @(negedge clk);
    sstb = 1'b1;
    repeat (3) @(negedge clk);
    sstb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    send_bits(w, 32);
    strobe();
  endtask

  task automatic read_back(input logic [3:0] sel, output logic [31:0] word, output bit idle_bit);
    bit b;
    write_word({sel, 23'b0, 5'b01000});
    ser_bit(1'b1, idle_bit);
    for (int i = 0; i < 32; i++) begin
      ser_bit(1'b1, b);
      word[i] = b;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic rb_case(input logic [3:0] sel, input logic [31:0] exp);
    logic [31:0] got;
    bit idle;
    read_back(sel, got, idle);
    check("R6", {31'b0, idle}, 32'h0, "idle clock pin");
    check("R5", got, exp, "readback word");
    check("R7", {31'b0, rb}, 32'h0, "pin after readback");
  endtask

  initial begin
    logic [31:0] got;
    bit b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", {31'b0, rb}, 32'h0, "pin after reset");
    for (int k = 0; k < NR; k++) check("R1", cfg[k*W +: W], 32'h0, "register after reset");

    cur_req = "R2";
    write_word(32'hDEAD_BE01);
    write_word(32'h1234_5602);
    write_word(32'hCAFE_F006);
    repeat (4) @(negedge clk);
    check("R2", cfg[0*W +: W], 32'hDEAD_BE01, "reg1");
    check("R2", cfg[1*W +: W], 32'h1234_5602, "reg2");
    check("R2", cfg[5*W +: W], 32'hCAFE_F006, "reg6");

    cur_req = "R3";
    send_bits(32'h5555_5503, 31); strobe();
    check("R3", cfg[2*W +: W], 32'h0, "reg3 after 31-bit frame");
    send_bits(32'h7777_7704, 33); strobe();
    check("R3", cfg[3*W +: W], 32'h0, "reg4 after 33-bit frame");
    write_word(32'h0F0F_0F03);
    check("R3", cfg[2*W +: W], 32'h0F0F_0F03, "reg3 after good frame");

    cur_req = "R4";
    write_word(32'hFFFF_FF00);
    write_word(32'hFFFF_FFE7);
    write_word(32'hABCD_EF09);
    write_word(32'hFFFF_FFFF);
    check("R4", cfg[0*W +: W], 32'hDEAD_BE01, "reg1 after ignored codes");
    check("R4", cfg[1*W +: W], 32'h1234_5602, "reg2 after ignored codes");
    check("R4", cfg[2*W +: W], 32'h0F0F_0F03, "reg3 after ignored codes");
    check("R4", cfg[3*W +: W], 32'h0, "reg4 after ignored codes");
    check("R4", cfg[4*W +: W], 32'h0, "reg5 after ignored codes");
    check("R4", cfg[5*W +: W], 32'hCAFE_F006, "reg6 after ignored codes");

    cur_req = "R5";
    rb_case(4'd1, 32'hDEAD_BE01);
    rb_case(4'd6, 32'hCAFE_F006);
    rb_case(4'd7, 32'h1357_9BDF);
    rb_case(4'd8, 32'h0BAD_F00D);
    rb_case(4'd0, 32'h0);
    rb_case(4'd12, 32'h0);

    cur_req = "R8";
    write_word(32'h2468_AC05);
    check("R8", cfg[4*W +: W], 32'h2468_AC05, "write right after readback");

    cur_req = "R9";
    write_word({4'd1, 23'b0, 5'b01000});
    ser_bit(1'b1, b);
    ser_bit(1'b1, b);
    check("R9", {31'b0, b}, 32'h1, "first bit before abort");
    strobe();
    check("R9", {31'b0, rb}, 32'h0, "pin after abort");
    write_word(32'h1111_1104);
    check("R9", cfg[3*W +: W], 32'h1111_1104, "write after abort");
    rb_case(4'd4, 32'h1111_1104);

    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule